// File: doc/BRIEF.md
# Memory Error Event Router

This block gathers hardware fault events from a DRAM controller and a thermal monitor and turns them into requests for outgoing system messages. Four event lines are watched: a multi-bit ECC error, a single-bit ECC error, a DRAM read/write throttle condition and a thermal trip. Each event pulse sets a sticky flag in a status register. Three routing registers, one for each message kind (system-error, system-management, system-control), decide per source whether a newly set flag asks for a message of that kind.

Requests that arise in the same cycle are held in a small pending set and leave the block one per cycle. Each request shows the kind of message and the source code. A plain register port with combinational read data gives software access to the status flags and the three routing registers. The encoding of messages on any link is outside this block.

Top module: `err_event_router`

## Requirements
- R1: The system-error routing register (address 1) has one enable per source at bit positions multi-bit ECC = 0, single-bit ECC = 1, throttle = 2. Bit 3 (thermal) is reserved.
- R2: Status (address 0) holds one sticky flag per source, using the same bit positions as R1 and thermal at bit 3. A pulse on `evt_i[s]` sets flag s. Writing 1 to a flag bit clears it. When an event and a clear hit the same flag in one cycle, the flag stays set.
- R3: A request for kind k and source s arises only in the cycle a flag goes from clear to set, and only if routing bit s of kind k is 1 in that cycle. A flag that stays set, or an enable turned on later, raises nothing.
- R4: After reset all flags and enables are 0 and no request is issued until an event occurs.
- R5: One thermal trip yields at most one request. It goes to system-management if that kind is enabled for thermal, else to system-control if enabled, else nowhere.
- R6: Reserved routing bits read as 0 and ignore writes: bit 3 at address 1, and bit 2 at addresses 2 and 3.
- R7: The system-management (address 2) and system-control (address 3) routing registers each have enables for multi-bit ECC (bit 0), single-bit ECC (bit 1) and thermal (bit 3).
- R8: Requests are issued one per cycle, one cycle after the event is sampled at the earliest. All system-error requests leave before system-management requests, and those before system-control requests. Within a kind, the lower source index leaves first. `msg_kind_o` is 0 for system-error, 1 for system-management and 2 for system-control. `msg_src_o` is the source bit position.
- R9: `cfg_rdata_o` shows, without delay, the register selected by `cfg_addr_i`: 0 is status, 1 to 3 are the routing registers in the order system-error, system-management, system-control.
- R10: A kind/source pair that is already waiting absorbs a repeat of itself. It is issued once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 4 | Event pulses: bit 0 multi-bit ECC, bit 1 single-bit ECC, bit 2 throttle, bit 3 thermal trip |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select |
| cfg_wdata_i | input | 4 | Register write data |
| cfg_rdata_o | output | 4 | Register read data |
| msg_req_o | output | 1 | One-cycle message request |
| msg_kind_o | output | 2 | Message kind of the request |
| msg_src_o | output | 2 | Source code of the request |

## Verification
The assertions take the event inputs to be known, synchronous levels, one bit per source, that are sampled on every rising edge. They take register writes to be single-cycle strobes whose address and data are stable across the edge. The bench drives every input just after a falling edge and holds it for one whole cycle. It never leaves an input undriven after reset. It uses only the four defined addresses, and its pseudo-random phase keeps events sparse so that queued requests drain between bursts.

// File: rtl/err_route_pkg.sv
package err_route_pkg;

   // message kind codes, in issue priority order
   localparam int unsigned KIND_SERR = 0;
   localparam int unsigned KIND_SMI  = 1;
   localparam int unsigned KIND_SCI  = 2;

   // source bit positions, in issue priority order within one kind
   localparam int unsigned SRC_ECC_MULTI  = 0;
   localparam int unsigned SRC_ECC_SINGLE = 1;
   localparam int unsigned SRC_THROTTLE   = 2;
   localparam int unsigned SRC_THERMAL    = 3;

   localparam int unsigned DEF_NUM_SRC  = 4;
   localparam int unsigned DEF_NUM_KIND = 3;

   // legal routing bits, one nibble per kind, kind 0 in the low nibble
   localparam logic [DEF_NUM_KIND*DEF_NUM_SRC-1:0] DEF_ROUTE_MASK = 12'b1011_1011_0111;

   // sources that may raise only one message per event
   localparam logic [DEF_NUM_SRC-1:0] DEF_SINGLE_MASK = 4'b1000;

endpackage

// File: rtl/err_status_bank.sv
module err_status_bank #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned NUM_KIND = 3,
   parameter int unsigned ADDR_W   = 2,
   parameter logic [NUM_KIND*NUM_SRC-1:0] ROUTE_MASK = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_SRC-1:0]           evt,
   input  logic                         wr,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [NUM_SRC-1:0]           wdata,
   output logic [NUM_SRC-1:0]           flags,
   output logic [NUM_SRC-1:0]           rise,
   output logic [NUM_KIND*NUM_SRC-1:0]  kind_en,
   output logic [NUM_SRC-1:0]           rdata
);

   logic [NUM_SRC-1:0] flags_q;
   logic [NUM_SRC-1:0] clr_bits;

   assign clr_bits = (wr && addr == '0) ? wdata : '0;

   // sticky flags: a new event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_bits) | evt;
   end

   assign flags = flags_q;
   assign rise  = evt & ~flags_q;

   for (genvar k = 0; k < NUM_KIND; k++) begin : g_kind
      localparam logic [NUM_SRC-1:0] LEGAL = ROUTE_MASK[k*NUM_SRC +: NUM_SRC];
      logic [NUM_SRC-1:0] en_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            en_r <= '0;
         else if (wr && int'(addr) == k + 1)    en_r <= wdata & LEGAL;
      end
      assign kind_en[k*NUM_SRC +: NUM_SRC] = en_r;
   end

   always_comb begin
      rdata = '0;
      if (addr == '0) rdata = flags_q;
      for (int k = 0; k < int'(NUM_KIND); k++) begin
         if (int'(addr) == k + 1) rdata = kind_en[k*NUM_SRC +: NUM_SRC];
      end
   end

endmodule

// File: rtl/err_req_route.sv
module err_req_route #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned NUM_KIND = 3,
   parameter logic [NUM_SRC-1:0] SINGLE_MSG_MASK = '0
) (
   input  logic [NUM_SRC-1:0]           rise,
   input  logic [NUM_KIND*NUM_SRC-1:0]  kind_en,
   output logic [NUM_KIND*NUM_SRC-1:0]  new_req
);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      logic [NUM_KIND-1:0] hit;
      logic [NUM_KIND-1:0] col;

      for (genvar k = 0; k < NUM_KIND; k++) begin : g_hit
         assign hit[k] = rise[s] & kind_en[k*NUM_SRC + s];
      end

      if (SINGLE_MSG_MASK[s]) begin : g_single
         // only the first enabled kind in priority order takes the event
         always_comb begin
            logic taken;
            taken = 1'b0;
            col   = '0;
            for (int k = 0; k < int'(NUM_KIND); k++) begin
               col[k] = hit[k] & ~taken;
               taken  = taken | hit[k];
            end
         end
      end else begin : g_fanout
         assign col = hit;
      end

      for (genvar k = 0; k < NUM_KIND; k++) begin : g_out
         assign new_req[k*NUM_SRC + s] = col[k];
      end
   end

endmodule

// File: rtl/err_msg_queue.sv
module err_msg_queue #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned NUM_KIND = 3,
   parameter int unsigned SRC_W    = 2,
   parameter int unsigned KIND_W   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_KIND*NUM_SRC-1:0]  new_req,
   output logic                         req,
   output logic [KIND_W-1:0]            kind,
   output logic [SRC_W-1:0]             src
);

   localparam int unsigned SLOTS = NUM_KIND * NUM_SRC;
   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   logic [SLOTS-1:0] pend_q;
   logic [SLOTS-1:0] grant;
   logic [IDX_W-1:0] sel;

   // lowest flat index wins: kind-major, then source order
   always_comb begin
      sel   = '0;
      grant = '0;
      for (int i = int'(SLOTS) - 1; i >= 0; i--) begin
         if (pend_q[i]) sel = IDX_W'(i);
      end
      if (|pend_q) grant[sel] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~grant) | new_req;
   end

   assign req  = |pend_q;
   assign kind = KIND_W'(int'(sel) / int'(NUM_SRC));
   assign src  = SRC_W'(int'(sel) % int'(NUM_SRC));

endmodule

// File: rtl/err_event_router.sv
module err_event_router
   import err_route_pkg::*;
#(
   parameter int unsigned NUM_SRC  = DEF_NUM_SRC,
   parameter int unsigned NUM_KIND = DEF_NUM_KIND,
   parameter logic [NUM_KIND*NUM_SRC-1:0] ROUTE_MASK = DEF_ROUTE_MASK,
   parameter logic [NUM_SRC-1:0] SINGLE_MSG_MASK = DEF_SINGLE_MASK,
   localparam int unsigned SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
   localparam int unsigned KIND_W = (NUM_KIND > 1) ? $clog2(NUM_KIND) : 1,
   localparam int unsigned ADDR_W = $clog2(NUM_KIND + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   evt_i,
   input  logic                 cfg_wr_i,
   input  logic [ADDR_W-1:0]    cfg_addr_i,
   input  logic [NUM_SRC-1:0]   cfg_wdata_i,
   output logic [NUM_SRC-1:0]   cfg_rdata_o,
   output logic                 msg_req_o,
   output logic [KIND_W-1:0]    msg_kind_o,
   output logic [SRC_W-1:0]     msg_src_o
);

   if (NUM_SRC < 1) begin : g_chk_src
      $error("err_event_router: NUM_SRC must be at least 1");
   end
   if (NUM_KIND < 1) begin : g_chk_kind
      $error("err_event_router: NUM_KIND must be at least 1");
   end
   if (ROUTE_MASK == '0) begin : g_chk_route
      $error("err_event_router: ROUTE_MASK routes no source");
   end

   logic [NUM_SRC-1:0]           stat_flags;
   logic [NUM_SRC-1:0]           stat_rise;
   logic [NUM_KIND*NUM_SRC-1:0]  kind_en;
   logic [NUM_KIND*NUM_SRC-1:0]  new_req;

   err_status_bank #(
      .NUM_SRC(NUM_SRC), .NUM_KIND(NUM_KIND), .ADDR_W(ADDR_W), .ROUTE_MASK(ROUTE_MASK)
   ) i_bank (
      .clk(clk), .rst_n(rst_n), .evt(evt_i), .wr(cfg_wr_i), .addr(cfg_addr_i),
      .wdata(cfg_wdata_i), .flags(stat_flags), .rise(stat_rise),
      .kind_en(kind_en), .rdata(cfg_rdata_o)
   );

   err_req_route #(
      .NUM_SRC(NUM_SRC), .NUM_KIND(NUM_KIND), .SINGLE_MSG_MASK(SINGLE_MSG_MASK)
   ) i_route (
      .rise(stat_rise), .kind_en(kind_en), .new_req(new_req)
   );

   err_msg_queue #(
      .NUM_SRC(NUM_SRC), .NUM_KIND(NUM_KIND), .SRC_W(SRC_W), .KIND_W(KIND_W)
   ) i_queue (
      .clk(clk), .rst_n(rst_n), .new_req(new_req),
      .req(msg_req_o), .kind(msg_kind_o), .src(msg_src_o)
   );

endmodule

// File: rtl/err_event_router_chk.sv
module err_event_router_chk #(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned NUM_KIND = 3,
   parameter logic [NUM_KIND*NUM_SRC-1:0] ROUTE_MASK = '1,
   parameter logic [NUM_SRC-1:0] SINGLE_MSG_MASK = '0,
   parameter int unsigned SRC_W  = 2,
   parameter int unsigned KIND_W = 2,
   parameter int unsigned ADDR_W = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_SRC-1:0]           evt_i,
   input logic                         cfg_wr_i,
   input logic [ADDR_W-1:0]            cfg_addr_i,
   input logic [NUM_SRC-1:0]           cfg_wdata_i,
   input logic [NUM_SRC-1:0]           cfg_rdata_o,
   input logic                         msg_req_o,
   input logic [KIND_W-1:0]            msg_kind_o,
   input logic [SRC_W-1:0]             msg_src_o,
   input logic [NUM_SRC-1:0]           flags,
   input logic [NUM_KIND*NUM_SRC-1:0]  new_req
);

   localparam int unsigned SLOTS = NUM_KIND * NUM_SRC;

   logic [NUM_SRC-1:0] legal_rd;
   logic               pair_ok;
   logic               seen_evt;
   int                 pair_idx;

   always_comb begin
      legal_rd = '1;
      for (int k = 0; k < int'(NUM_KIND); k++) begin
         if (int'(cfg_addr_i) == k + 1) legal_rd = ROUTE_MASK[k*NUM_SRC +: NUM_SRC];
      end
   end

   assign pair_idx = int'(msg_kind_o) * int'(NUM_SRC) + int'(msg_src_o);
   assign pair_ok  = (pair_idx < int'(SLOTS)) ? ROUTE_MASK[pair_idx] : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      seen_evt <= 1'b0;
      else if (|evt_i) seen_evt <= 1'b1;
   end

   // R1 R7: a request only names a kind/source pair that routing allows
   p_legal_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
      msg_req_o |-> pair_ok);

   // R6: reserved routing bits never read back as 1
   p_reserved_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata_o & ~legal_rd) == '0);

   // R4: nothing is requested before the first event since reset
   p_quiet_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_evt |-> !msg_req_o);

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      // R2: an event pulse leaves its flag set
      p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         evt_i[s] |=> flags[s]);

      // R2: a set flag only drops after a write-one-to-clear
      p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
         flags[s] |=> (flags[s] || $past(cfg_wr_i && cfg_addr_i == '0 && cfg_wdata_i[s])));

      if (SINGLE_MSG_MASK[s]) begin : g_single
         logic [NUM_KIND-1:0] col;
         for (genvar k = 0; k < NUM_KIND; k++) begin : g_col
            assign col[k] = new_req[k*NUM_SRC + s];
         end
         // R5: one event of this source raises at most one request
         p_single_msg_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
      end
   end

endmodule

bind err_event_router err_event_router_chk #(
   .NUM_SRC(NUM_SRC), .NUM_KIND(NUM_KIND), .ROUTE_MASK(ROUTE_MASK),
   .SINGLE_MSG_MASK(SINGLE_MSG_MASK), .SRC_W(SRC_W), .KIND_W(KIND_W), .ADDR_W(ADDR_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg_wr_i(cfg_wr_i),
   .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
   .msg_req_o(msg_req_o), .msg_kind_o(msg_kind_o), .msg_src_o(msg_src_o),
   .flags(stat_flags), .new_req(new_req)
);

// File: tb/test_err_event_router.sv
`timescale 1ns/1ps
module test_err_event_router;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] evt_i = '0;
   logic       cfg_wr_i = 1'b0;
   logic [1:0] cfg_addr_i = '0;
   logic [3:0] cfg_wdata_i = '0;
   logic [3:0] cfg_rdata_o;
   logic       msg_req_o;
   logic [1:0] msg_kind_o;
   logic [1:0] msg_src_o;

   always #2 clk = ~clk;   // 250 MHz

   err_event_router i_err_event_router (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .cfg_wr_i(cfg_wr_i),
      .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
      .msg_req_o(msg_req_o), .msg_kind_o(msg_kind_o), .msg_src_o(msg_src_o)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   // reference model
   bit       m_flag [4];
   bit [3:0] m_en   [3];
   bit       m_pend [3][4];
   bit [3:0] m_legal [3] = '{4'b0111, 4'b1011, 4'b1011};

   // last sampled outputs
   int last_code;
   int last_rd;

   task automatic cmp(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int s = 0; s < 4; s++) m_flag[s] = 0;
      for (int k = 0; k < 3; k++) begin
         m_en[k] = '0;
         for (int s = 0; s < 4; s++) m_pend[k][s] = 0;
      end
   endtask

   function automatic int model_code();
      for (int k = 0; k < 3; k++)
         for (int s = 0; s < 4; s++)
            if (m_pend[k][s]) return k * 4 + s;
      return -1;
   endfunction

   function automatic int model_read(int a);
      int v = 0;
      if (a == 0) begin
         for (int s = 0; s < 4; s++) if (m_flag[s]) v |= (1 << s);
      end else v = int'(m_en[a-1]);
      return v;
   endfunction

   task automatic model_update(bit [3:0] ev, bit wr, int a, bit [3:0] d);
      int c = model_code();
      if (c >= 0) m_pend[c/4][c%4] = 0;
      // new requests on a clear-to-set flag; R10: a waiting pair just stays set
      for (int s = 0; s < 4; s++) begin
         if (ev[s] && !m_flag[s]) begin
            bit claimed = 0;
            for (int k = 0; k < 3; k++) begin
               if (m_en[k][s]) begin
                  if (s != 3 || !claimed) m_pend[k][s] = 1;
                  claimed = 1;
               end
            end
         end
      end
      if (wr && a == 0) for (int s = 0; s < 4; s++) if (d[s]) m_flag[s] = 0;
      for (int s = 0; s < 4; s++) if (ev[s]) m_flag[s] = 1;
      if (wr && a != 0) m_en[a-1] = d & m_legal[a-1];
   endtask

   task automatic step(bit [3:0] ev, bit wr, int a, bit [3:0] d);
      int exp_code;
      int act_code;
      @(negedge clk);
      evt_i = ev; cfg_wr_i = wr; cfg_addr_i = 2'(a); cfg_wdata_i = d;
      #1;
      exp_code = model_code();
      act_code = msg_req_o ? int'(msg_kind_o) * 4 + int'(msg_src_o) : -1;
      cmp("R3 R8 R10 message kind*4+src", act_code, exp_code);
      cmp("R9 R2 read data", int'(cfg_rdata_o), model_read(a));
      last_code = act_code;
      last_rd   = int'(cfg_rdata_o);
      model_update(ev, wr, a, d);
   endtask

   task automatic idle(); step(4'h0, 0, 0, 4'h0); endtask
   task automatic wr_reg(int a, bit [3:0] d); step(4'h0, 1, a, d); endtask
   task automatic rd_reg(int a); step(4'h0, 0, a, 4'h0); endtask

   initial begin
      int order [8] = '{0, 1, 2, 4, 5, 7, 8, 9};
      bit [31:0] rng = 32'h1234_5678;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4: reset state
      for (int a = 0; a < 4; a++) begin
         rd_reg(a);
         cmp("R4 register after reset", last_rd, 0);
         cmp("R4 no request after reset", last_code, -1);
      end

      // R6 R1 R7: legal routing bits
      wr_reg(1, 4'hF); rd_reg(1); cmp("R1 R6 error routing readback", last_rd, 7);
      wr_reg(2, 4'hF); rd_reg(2); cmp("R7 R6 management routing readback", last_rd, 11);
      wr_reg(3, 4'hF); rd_reg(3); cmp("R7 R6 control routing readback", last_rd, 11);
      wr_reg(1, 4'h0); wr_reg(2, 4'h0); wr_reg(3, 4'h0);

      // R3: events with routing off raise nothing
      step(4'hF, 0, 0, 4'h0);
      for (int i = 0; i < 3; i++) begin
         rd_reg(0);
         cmp("R3 no request with routing off", last_code, -1);
      end
      cmp("R2 flags set by events", last_rd, 15);

      // R2: sticky, write-one-to-clear, event wins over clear
      step(4'hF, 0, 0, 4'h0);
      rd_reg(0); cmp("R2 flags stay set", last_rd, 15);
      wr_reg(0, 4'h3); rd_reg(0); cmp("R2 clear bits 0 and 1", last_rd, 12);
      step(4'h4, 1, 0, 4'h4); rd_reg(0); cmp("R2 event beats clear", last_rd, 12);
      wr_reg(0, 4'hF); rd_reg(0); cmp("R2 clear all", last_rd, 0);

      // R8 R5: burst with every kind enabled
      wr_reg(1, 4'hF); wr_reg(2, 4'hF); wr_reg(3, 4'hF);
      step(4'hF, 0, 0, 4'h0);
      for (int i = 0; i < 8; i++) begin
         idle();
         cmp("R8 R5 issue order", last_code, order[i]);
      end
      idle(); cmp("R8 queue drained", last_code, -1);

      // R5: thermal falls through to control when management is off
      wr_reg(2, 4'h0); wr_reg(0, 4'hF);
      step(4'h8, 0, 0, 4'h0);
      idle(); cmp("R5 thermal to control", last_code, 11);
      idle(); cmp("R5 only one thermal request", last_code, -1);

      // R3: late enable on a set flag raises nothing
      wr_reg(1, 4'h0); wr_reg(0, 4'hF);
      step(4'h1, 0, 0, 4'h0);
      wr_reg(1, 4'h1);
      for (int i = 0; i < 3; i++) begin
         idle();
         cmp("R3 late enable no request", last_code, -1);
      end

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         bit [3:0] ev;
         rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
         ev = rng[3:0] & rng[7:4] & rng[11:8];
         step(ev, rng[15:13] == 3'b000, int'(rng[17:16]), rng[21:18]);
      end

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not end, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule